// File: doc/BRIEF.md
# Precision Time Counter with Event Capture

A free-running nanosecond time-of-day counter for a precision time protocol unit. On every reference tick it adds a programmable increment to a 64-bit nanosecond value. The increment is a fixed-point value with 32 integer bits and 32 fractional bits. A hidden 32-bit fraction sits below the nanosecond value, so that increments which are not whole nanoseconds still average out exactly. The tick comes from the block clock, or from the rising edges of a selected external reference input. That input is synchronised and sampled in the block clock domain, so no clock is ever switched.

A second set of inputs carries trigger pulses, such as a one-pulse-per-second signal from an external timing device. When capture is enabled, the chosen edge of the selected trigger latches the current time into a capture register. The register holds that value until the next qualifying edge. Software polls the capture register and treats a changed value as a new event. Software then uses the captured time to align its own output pulses to the external source.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the config, increment, time, fraction and capture values all read zero.
- R2: While config bit 0 is clear, the time value does not change except through a register load.
- R3: With config bit 0 set and bit 1 clear, each clock adds the increment. The increment's high word (address 2) is whole nanoseconds and its low word (address 1) is a binary fraction. Fraction carries reach the nanosecond value, so 1.25 ns added over 8 clocks advances time by exactly 10.
- R4: With config bits 0 and 1 set, only rising edges of the reference input chosen by config bits 7:2 add the increment. Edges on other reference inputs have no effect.
- R5: A write to address 3 replaces the low 32 bits of time, and a write to address 4 replaces the high 32 bits. Either write clears the fraction (read at address 7). The load takes precedence over a tick in the same cycle.
- R6: With config bit 8 set, the trigger input chosen by bits 15:10 is captured. Bit 9 selects the edge: 0 for rising, 1 for falling. The capture holds the time that time_ns shows two clocks after the input change, and it appears one clock later.
- R7: No capture happens while bit 8 is clear, on the non-selected edge, or on a non-selected trigger input.
- R8: Each qualifying edge causes exactly one capture, however long the level is held. The captured value is kept until the next qualifying edge.
- R9: Reads return config at address 0, increment low and high at addresses 1 and 2, time low and high at addresses 3 and 4, and capture low and high at addresses 5 and 6.
- R10: A reference or trigger select value at or beyond the number of inputs acts as a constantly low input. It produces no ticks and no captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | NREF | External reference inputs, asynchronous |
| trig_in | input | NTRIG | External trigger inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| time_ns | output | 64 | Current time in nanoseconds |
| cap_ns | output | 64 | Last captured time |

## Verification
A wrong fraction or a lost carry shows at time_ns within a few ticks, as a difference from the whole-nanosecond total expected over an exact number of clocks. A wrong edge detector or a false select shows at cap_ns three clocks after the trigger moves. It appears as a missing, extra or shifted capture. The scoreboard flags this at once, because every change on cap_ns must match a queued expectation. A stale fraction after a load shows on the very next read of address 7.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int NREF  = 4,
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREF-1:0]  ref_in,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [63:0]      time_ns,
  output logic [63:0]      cap_ns
);
  localparam logic [2:0] A_CFG = 3'd0, A_INCL = 3'd1, A_INCH = 3'd2,
                         A_TLO = 3'd3, A_THI = 3'd4, A_CLO = 3'd5,
                         A_CHI = 3'd6, A_FRC = 3'd7;

  logic [15:0]      cfg;
  logic [63:0]      inc;
  logic [95:0]      acc;
  logic [63:0]      cap_q;
  logic [NREF-1:0]  rs1, rs2, rs3;
  logic [NTRIG-1:0] ts1, ts2, ts3;

  wire [63:0] ref_cur  = 64'(rs2);
  wire [63:0] ref_old  = 64'(rs3);
  wire [63:0] trig_cur = 64'(ts2);
  wire [63:0] trig_old = 64'(ts3);
  wire        ref_rise = ref_cur[cfg[7:2]] & ~ref_old[cfg[7:2]];
  wire        t_now    = trig_cur[cfg[15:10]];
  wire        t_was    = trig_old[cfg[15:10]];
  wire        trig_hit = cfg[8] & (cfg[9] ? (t_was & ~t_now) : (t_now & ~t_was));
  wire        tick     = cfg[0] & (cfg[1] ? ref_rise : 1'b1);
  wire        wr_tlo   = reg_wr && reg_addr == A_TLO;
  wire        wr_thi   = reg_wr && reg_addr == A_THI;
  wire [95:0] acc_next = acc + {32'd0, inc};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {rs1, rs2, rs3} <= '0;
      {ts1, ts2, ts3} <= '0;
    end else begin
      rs1 <= ref_in;  rs2 <= rs1; rs3 <= rs2;
      ts1 <= trig_in; ts2 <= ts1; ts3 <= ts2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg <= '0;
      inc <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CFG)  cfg        <= reg_wdata[15:0];
      if (reg_addr == A_INCL) inc[31:0]  <= reg_wdata;
      if (reg_addr == A_INCH) inc[63:32] <= reg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      acc <= '0;
    else if (wr_tlo) acc <= {acc[95:64], reg_wdata, 32'd0};
    else if (wr_thi) acc <= {reg_wdata, acc[63:32], 32'd0};
    else if (tick)   acc <= acc_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cap_q <= '0;
    else if (trig_hit) cap_q <= acc[95:32];

  assign time_ns = acc[95:32];
  assign cap_ns  = cap_q;

  always_comb
    case (reg_addr)
      A_CFG:   reg_rdata = {16'd0, cfg};
      A_INCL:  reg_rdata = inc[31:0];
      A_INCH:  reg_rdata = inc[63:32];
      A_TLO:   reg_rdata = acc[63:32];
      A_THI:   reg_rdata = acc[95:64];
      A_CLO:   reg_rdata = cap_q[31:0];
      A_CHI:   reg_rdata = cap_q[63:32];
      default: reg_rdata = acc[31:0];
    endcase

  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[0] && !wr_tlo && !wr_thi) |=> $stable(time_ns));

  a_r3_whole_ns_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && !cfg[1] && inc[63:32] != 0 && !wr_tlo && !wr_thi) |=> time_ns != $past(time_ns));

  a_r4_no_ref_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1] && !(rs2[0] === 1'bx) && !ref_rise && !wr_tlo && !wr_thi) |=> $stable(time_ns));

  a_r5_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tlo |=> (time_ns[31:0] == $past(reg_wdata) && acc[31:0] == 32'd0));

  a_r5_high_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thi |=> (time_ns[63:32] == $past(reg_wdata) && acc[31:0] == 32'd0));

  a_r7_capture_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[8] |=> $stable(cap_ns));
endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [3:0]  ref_in = 0, trig_in = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] time_ns, cap_ns;
  int checks = 0, errors = 0;
  logic [63:0] expq[$];
  bit finished = 0;

  ptp_time_counter dut (.clk, .rst_n, .ref_in, .trig_in, .reg_wr, .reg_addr,
                        .reg_wdata, .reg_rdata, .time_ns, .cap_ns);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_pulse(int idx);
    @(negedge clk); ref_in[idx] = 1; settle(3);
    ref_in[idx] = 0; settle(3);
  endtask

  task automatic trig_set(int idx, logic lvl, bit expect_cap);
    @(negedge clk); trig_in[idx] = lvl;
    settle(2);
    if (expect_cap) expq.push_back(time_ns);
    settle(5);
  endtask

  initial begin : monitor
    logic [63:0] last = 0;
    forever begin
      @(negedge clk);
      if (finished) break;
      if (rst_n && cap_ns !== last) begin
        if (expq.size() == 0) chk("R7 unexpected capture", cap_ns, last);
        else chk("R6 capture value", cap_ns, expq.pop_front());
        last = cap_ns;
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] t0, t1;
    settle(2); rst_n = 1; settle(1);
    rd(3'd0, d); chk("R1 cfg", 64'(d), 0);
    rd(3'd2, d); chk("R1 inc", 64'(d), 0);
    rd(3'd7, d); chk("R1 frac", 64'(d), 0);
    chk("R1 time", time_ns, 0);
    chk("R1 capture", cap_ns, 0);

    wr(3'd4, 32'h1); wr(3'd3, 32'h10);
    chk("R5 load", time_ns, 64'h1_0000_0010);
    wr(3'd2, 3); settle(1); t0 = time_ns; settle(5);
    chk("R2 disabled hold", time_ns, t0);

    wr(3'd0, 32'h1); settle(1); t0 = time_ns; settle(5); t1 = time_ns;
    chk("R3 whole increment", t1 - t0, 15);
    wr(3'd0, 0); wr(3'd2, 1); wr(3'd1, 32'h4000_0000);
    wr(3'd0, 1); settle(1); t0 = time_ns; settle(8); t1 = time_ns;
    chk("R3 fractional carry", t1 - t0, 10);
    wr(3'd0, 0);
    rd(3'd1, d); chk("R9 inc low", 64'(d), 32'h4000_0000);
    rd(3'd0, d); chk("R9 cfg", 64'(d), 0);

    wr(3'd1, 32'hC000_0000); wr(3'd2, 0); wr(3'd0, 1); settle(3); wr(3'd0, 0);
    wr(3'd3, 32'h55);
    rd(3'd7, d); chk("R5 fraction cleared", 64'(d), 0);
    chk("R5 low half", {32'd0, time_ns[31:0]}, 32'h55);

    wr(3'd1, 0); wr(3'd2, 7); wr(3'd0, 32'h0B); settle(4); t0 = time_ns;
    repeat (4) ref_pulse(2);
    settle(4); chk("R4 selected reference", time_ns - t0, 28);
    t0 = time_ns; repeat (3) ref_pulse(1);
    settle(4); chk("R4 other reference ignored", time_ns - t0, 0);
    wr(3'd0, 32'hFF); settle(4); t0 = time_ns;
    for (int i = 0; i < 4; i++) ref_pulse(i);
    settle(4); chk("R10 reference out of range", time_ns - t0, 0);

    wr(3'd2, 3); wr(3'd0, 32'h501); settle(3);
    trig_set(1, 1, 1); settle(10); trig_set(1, 0, 0);
    trig_set(1, 1, 1); trig_set(1, 0, 0);
    trig_set(0, 1, 0); trig_set(0, 0, 0);
    rd(3'd5, d); chk("R9 capture low", 64'(d), {32'd0, cap_ns[31:0]});
    rd(3'd6, d); chk("R8 capture held", 64'(d), {32'd0, cap_ns[63:32]});
    wr(3'd0, 32'h701); settle(3);
    trig_set(1, 1, 0); trig_set(1, 0, 1);
    wr(3'd0, 32'h401); settle(3);
    trig_set(1, 1, 0); trig_set(1, 0, 0);
    wr(3'd0, 32'hFD01); settle(3);
    for (int i = 0; i < 4; i++) begin trig_set(i, 1, 0); trig_set(i, 0, 0); end
    settle(4);
    chk("R8 all captures seen", 64'(expq.size()), 0);
    finished = 1;
    finish_run();
  end
endmodule